// File: doc/BRIEF.md
# 64-bit System Tick Timer

This block is a free-running 64-bit tick counter for a processor subsystem. Software programs it through a small 32-bit register bus. Each 64-bit quantity, the live count and the compare value, is reached as two 32-bit words, with the low word at the lower address. A control word sets the following:

- whether the timer runs;
- whether a match raises the interrupt request;
- whether the count steps on every clock or once per eight clocks;
- whether the count goes up or down;
- whether the count reloads when it reaches its end point.

The control word also carries a one-shot bit that loads the starting value.

A match event happens when the counter steps from its end point. In up mode the end point is the compare value. In down mode it is zero. A match sets a sticky status flag, and that flag gates the interrupt output. With reload on, loading the compare value with N-1 gives a periodic event every N steps in either direction.

Top module: `stk_timer`

## Requirements
- R1: After reset the control word, status word, counter and compare value all read 0 and irq_o is low.
- R2: Word offsets: control 0x00, status 0x04, counter low 0x08, counter high 0x0C, compare low 0x10, compare high 0x14. A write to any of these words is read back unchanged on the next cycle. Control bits 4:0 read back as written. Status holds only bit 0.
- R3: Control bit 0 enables counting. While it is 0 the counter holds its value.
- R4: If control bit 2 is 1, the counter steps once per enabled clock. If it is 0, the counter steps once every 8 enabled clocks, and the divider restarts while counting is disabled and on every init write.
- R5: With control bit 4 at 0 (up mode), each step adds 1, carrying across the word boundary. A step taken while the count equals the compare value is a match. With control bit 3 (reload) at 1 that step returns the count to 0. With reload at 0 the count keeps incrementing and wraps past all ones.
- R6: With control bit 4 at 1 (down mode), each step subtracts 1. A step taken at 0 is a match. With reload at 1 that step loads the compare value. With reload at 0 the count wraps to all ones.
- R7: With reload on and the compare value set to N-1, a match occurs every N steps in both modes.
- R8: A control write with bit 5 set loads 0 if the written bit 4 is 0, or the compare value if the written bit 4 is 1. Bit 5 always reads back as 0.
- R9: Status bit 0 is set by a match and stays set. Writing 0 to it clears it. Writing 1 to it has no effect. A match in the same cycle as a clear leaves it set.
- R10: irq_o is high exactly when status bit 0 and control bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_addr_i | input | 5 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed word, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational from the address. A register write becomes visible on the first sampling point after the clock edge that captured it. Every check therefore samples at the falling edge that follows that edge.

In fast mode, the counter steps on each edge after the enabling write, up to and including the edge of the write that stops it. A run of k cycles therefore gives k steps in fast mode and floor(k/8) steps in slow mode.

The bench stops the counter before it reads the two words, so the high and low halves are always consistent. The expected count and flag come from closed-form functions of the mode, the reload setting, the compare value and the step count.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned STAT_IDX = 1;
  localparam int unsigned CNT_IDX  = 2;
  localparam int unsigned INIT_BIT = 5;

  // control bits 4..0
  typedef struct packed {
    logic mode_down;
    logic reload;
    logic fast_clk;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/stk_prescale.sv
module stk_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || restart_i) div_q <= '0;
    else if (div_q == LAST)     div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (fast_i || div_q == LAST);
endmodule

// File: rtl/stk_counter.sv
module stk_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             reload_i,
  input  logic             init_i,
  input  logic             init_down_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W/BUS_W-1:0] ld_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  localparam int unsigned NW = CNT_W / BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end  = down_i ? (cnt_q == '0) : (cnt_q == cmp_i);
  assign match_o = tick_i && !init_i && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (init_i) begin
      cnt_d = init_down_i ? cmp_i : '0;
    end else if (tick_i) begin
      if (down_i) cnt_d = (at_end && reload_i) ? cmp_i : cnt_q - 1'b1;
      else        cnt_d = (at_end && reload_i) ? '0    : cnt_q + 1'b1;
    end
    // software word writes take precedence
    for (int w = 0; w < NW; w++) begin
      if (ld_i[w]) cnt_d[w*BUS_W +: BUS_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stk_timer.sv
module stk_timer #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PRESCALE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  import stk_pkg::*;

  localparam int unsigned NW      = CNT_W / BUS_W;
  localparam int unsigned CMP_IDX = CNT_IDX + NW;
  localparam int unsigned IDX_W   = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CTRL_A = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] STAT_A = IDX_W'(STAT_IDX);

  logic [IDX_W-1:0] idx;
  logic             wr_ctrl, wr_stat, init_p, tick, match;
  logic [NW-1:0]    cnt_ld, cmp_ld;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             flag_q;

  assign idx     = bus_addr_i[ADDR_W-1:2];
  assign wr_ctrl = bus_we_i && idx == CTRL_A;
  assign wr_stat = bus_we_i && idx == STAT_A;
  assign init_p  = wr_ctrl && bus_wdata_i[INIT_BIT];

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign cnt_ld[g] = bus_we_i && idx == IDX_W'(CNT_IDX + g);
    assign cmp_ld[g] = bus_we_i && idx == IDX_W'(CMP_IDX + g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[g*BUS_W +: BUS_W] <= '0;
      else if (cmp_ld[g]) cmp_q[g*BUS_W +: BUS_W] <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[$bits(ctrl_t)-1:0]);
  end

  stk_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .restart_i(init_p),
    .fast_i   (ctrl_q.fast_clk),
    .tick_o   (tick)
  );

  stk_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .down_i     (ctrl_q.mode_down),
    .reload_i   (ctrl_q.reload),
    .init_i     (init_p),
    .init_down_i(bus_wdata_i[4]),
    .cmp_i      (cmp_q),
    .ld_i       (cnt_ld),
    .wdata_i    (bus_wdata_i),
    .cnt_o      (cnt_q),
    .match_o    (match)
  );

  // match wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (match)                    flag_q <= 1'b1;
    else if (wr_stat && !bus_wdata_i[0]) flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (idx == CTRL_A) bus_rdata_o[$bits(ctrl_t)-1:0] = ctrl_q;
    if (idx == STAT_A) bus_rdata_o[0] = flag_q;
    for (int w = 0; w < NW; w++) begin
      if (idx == IDX_W'(CNT_IDX + w)) bus_rdata_o = cnt_q[w*BUS_W +: BUS_W];
      if (idx == IDX_W'(CMP_IDX + w)) bus_rdata_o = cmp_q[w*BUS_W +: BUS_W];
    end
  end

  assign irq_o = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/stk_timer_chk.sv
module stk_timer_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic             stat_wr_i,
  input logic             stat_bit_i,
  input logic             tick_i,
  input logic             match_i,
  input logic             run_i,
  input logic             fast_i,
  input logic             down_i,
  input logic             reload_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic             flag_i
);
  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !bus_we_i) |=> $stable(cnt_i));

  a_r4_slow_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fast_i && !bus_we_i) |=> !tick_i);

  a_r5_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && fast_i && !down_i && cnt_i != cmp_i && !bus_we_i) |=> cnt_i == $past(cnt_i) + 1'b1);

  a_r5_up_reload_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !down_i && reload_i && cnt_i == cmp_i && !bus_we_i) |=> (cnt_i == '0 && flag_i));

  a_r6_down_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && down_i && cnt_i == '0 && !bus_we_i) |=> flag_i);

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !(stat_wr_i && !stat_bit_i)) |=> flag_i);

  a_r9_match_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_i);
endmodule

bind stk_timer stk_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_we_i  (bus_we_i),
  .stat_wr_i (wr_stat),
  .stat_bit_i(bus_wdata_i[0]),
  .tick_i    (tick),
  .match_i   (match),
  .run_i     (ctrl_q.run),
  .fast_i    (ctrl_q.fast_clk),
  .down_i    (ctrl_q.mode_down),
  .reload_i  (ctrl_q.reload),
  .cnt_i     (cnt_q),
  .cmp_i     (cmp_q),
  .flag_i    (flag_q)
);

// File: tb/stk_timer_tb_top.sv
`timescale 1ns/1ps
module stk_timer_tb_top;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CNT = 5'h08, A_CMP = 5'h10;
  localparam logic [31:0] B_RUN = 32'h01, B_IRQ = 32'h02, B_FAST = 32'h04,
                          B_RLD = 32'h08, B_DOWN = 32'h10, B_INIT = 32'h20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk_i = ~clk_i;

  stk_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic rd64(input logic [4:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 5'd4, hi);
    d = {hi, lo};
  endtask

  task automatic wr64(input logic [4:0] a, input logic [63:0] d);
    wr(a, d[31:0]);
    wr(a + 5'd4, d[63:32]);
  endtask

  // enable for k edges, then stop (stop write keeps the other bits)
  task automatic run(input logic [31:0] bits, input int k, input bit do_init);
    wr(A_CTRL, bits | B_RUN | (do_init ? B_INIT : 32'h0));
    repeat (k - 1) @(negedge clk_i);
    wr(A_CTRL, bits);
  endtask

  function automatic logic [63:0] exp_cnt(bit down, bit rld, logic [63:0] cmp, logic [63:0] t);
    if (!down) return rld ? t % (cmp + 64'd1) : t;
    return rld ? cmp - (t % (cmp + 64'd1)) : cmp - t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d32;
    logic [63:0] d64;
    void'($urandom(32'd20240515));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(A_CTRL, d32); chk("R1 ctrl", d32, 0);
    rd(A_STAT, d32); chk("R1 status", d32, 0);
    rd64(A_CNT, d64); chk("R1 counter", d64, 0);
    rd64(A_CMP, d64); chk("R1 compare", d64, 0);
    chk("R1 irq", irq_o, 0);

    // R2 readback
    wr64(A_CMP, 64'hA5A5_0001_5A5A_0002);
    rd64(A_CMP, d64); chk("R2 compare words", d64, 64'hA5A5_0001_5A5A_0002);
    wr64(A_CNT, 64'h0000_0007_1234_5678);
    rd64(A_CNT, d64); chk("R2 counter words", d64, 64'h0000_0007_1234_5678);
    wr(A_CTRL, B_IRQ | B_RLD | B_DOWN);
    rd(A_CTRL, d32); chk("R2 ctrl readback", d32, B_IRQ | B_RLD | B_DOWN);

    // R3 hold while disabled
    repeat (10) @(negedge clk_i);
    rd64(A_CNT, d64); chk("R3 hold when off", d64, 64'h0000_0007_1234_5678);

    // R8 init in down mode loads compare; init bit reads 0
    wr(A_CTRL, 0);
    wr64(A_CMP, 64'h0000_1234_0000_0009);
    wr(A_CTRL, B_DOWN | B_INIT);
    rd64(A_CNT, d64); chk("R8 init down", d64, 64'h0000_1234_0000_0009);
    rd(A_CTRL, d32); chk("R8 init self clear", d32, B_DOWN);
    wr(A_CTRL, B_INIT);
    rd64(A_CNT, d64); chk("R8 init up", d64, 0);

    // R5 carry across words, no reload
    wr(A_CTRL, 0);
    wr64(A_CMP, 64'hFFFF_FFFF_FFFF_FFFF);
    wr64(A_CNT, 64'h0000_0000_FFFF_FFFE);
    run(B_FAST, 3, 0);
    rd64(A_CNT, d64); chk("R5 carry", d64, 64'h0000_0001_0000_0001);

    // R6 down wrap without reload
    wr64(A_CMP, 64'd5);
    wr64(A_CNT, 64'd1);
    wr(A_STAT, 0);
    run(B_FAST | B_DOWN, 3, 0);
    rd64(A_CNT, d64); chk("R6 down wrap", d64, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(A_STAT, d32); chk("R6 zero flag", d32, 1);

    // R4 slow clock
    wr(A_STAT, 0);
    wr64(A_CMP, 64'd1000);
    run(0, 20, 1);
    rd64(A_CNT, d64); chk("R4 slow 20 cycles", d64, 2);
    run(0, 7, 1);
    rd64(A_CNT, d64); chk("R4 slow 7 cycles", d64, 0);

    // R9 / R10 flag and irq
    wr64(A_CMP, 64'd2);
    wr(A_STAT, 0);
    run(B_FAST | B_RLD | B_IRQ, 5, 1);
    rd(A_STAT, d32); chk("R9 flag set", d32, 1);
    chk("R10 irq high", irq_o, 1);
    wr(A_STAT, 1);
    rd(A_STAT, d32); chk("R9 write one no effect", d32, 1);
    wr(A_CTRL, B_FAST);
    chk("R10 irq masked", irq_o, 0);
    wr(A_CTRL, B_IRQ);
    chk("R10 irq unmasked", irq_o, 1);
    wr(A_STAT, 0);
    rd(A_STAT, d32); chk("R9 cleared", d32, 0);
    chk("R10 irq after clear", irq_o, 0);

    // R7 directed period: N=4, 8 steps -> back to start, flag set
    run(B_FAST | B_RLD | B_DOWN, 8, 1);
    wr64(A_CMP, 64'd3);
    run(B_FAST | B_RLD | B_DOWN, 8, 1);
    rd64(A_CNT, d64); chk("R7 down period", d64, 64'd3);

    // random trials: R4 R5 R6 R7
    for (int i = 0; i < 40; i++) begin
      logic [63:0] cmpv, t;
      int k;
      bit down, rld, fast;
      cmpv = 64'($urandom_range(1, 39));
      k    = $urandom_range(1, 100);
      down = 1'($urandom_range(0, 1));
      rld  = 1'($urandom_range(0, 1));
      fast = 1'($urandom_range(0, 1));
      t    = fast ? 64'(k) : 64'(k / 8);
      wr(A_CTRL, 0);
      wr64(A_CMP, cmpv);
      wr(A_STAT, 0);
      run((down ? B_DOWN : 0) | (rld ? B_RLD : 0) | (fast ? B_FAST : 0), k, 1);
      rd64(A_CNT, d64);
      chk(down ? (rld ? "R7 R6 down reload" : "R6 down") : (rld ? "R7 R5 up reload" : "R5 up"),
          d64, exp_cnt(down, rld, cmpv, t));
      rd(A_STAT, d32);
      chk("R9 random flag", d32, (t >= cmpv + 64'd1) ? 1 : 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule